// File: doc/BRIEF.md
# Static Memory Wait-State Timer

This block sequences one access at a time to a bank of external static memory chip selects. Each access has a fixed shape: a setup cycle with only the chip select active, then a strobe phase whose length is set by a programmed wait count, then a hold cycle. It ends with a single-cycle completion pulse. The strobe is output enable for reads and write enable for writes.

In normal mode, every chip select has its own short read wait count and its own short write wait count. A per-chip-select extended bit replaces both of them with one shared long-wait register. That register is scaled by sixteen, so very slow devices can be reached.

The wait length is captured when a request is accepted. The `busy` output covers the whole access, so an arbiter can hold off refresh or other masters until it ends.

Top module: `smc_wait_timer`

## Requirements
- R1: While reset is held and on the cycle after it is released, `cs_n` is all ones, `oe_n` and `we_n` are high, and `busy` and `done` are low.
- R2: A request seen at a clock edge while `busy` is low is accepted. From the next cycle `busy` is high and only bit `req_cs` of `cs_n` is low. That first cycle is a setup cycle with both strobes high.
- R3: A normal-mode read drives `oe_n` low for exactly read-wait-field + 1 cycles, giving 1 to 32. `we_n` stays high.
- R4: A normal-mode write drives `we_n` low for exactly write-wait-field + 1 cycles. `oe_n` stays high.
- R5: When the extended bit of the addressed chip select is set, reads and writes both hold the strobe low for 16 × long-wait-field cycles. A long-wait field of 0 still gives a one-cycle strobe. Chip selects whose extended bit is clear keep their normal timing.
- R6: After the strobe, one hold cycle follows with the chip select still low and both strobes high. On the next cycle `done` is high for exactly one cycle, `cs_n` is all ones and `busy` is low.
- R7: A request raised while `busy` is high is ignored. The active chip select does not change, and no access follows once the request is withdrawn.
- R8: A configuration write made during an access does not change that access's strobe length. It applies from the next access.
- R9: Configuration register select `cfg_sel` uses these values: 0 is the read wait of `cfg_cs` (`cfg_wdata[4:0]`); 1 is the write wait of `cfg_cs` (`cfg_wdata[4:0]`); 2 is the extended bit of `cfg_cs` (`cfg_wdata[0]`); 3 is the shared long-wait field (`cfg_wdata[9:0]`, `cfg_cs` ignored).
- R10: A long-wait field of 1023 yields a 16368-cycle strobe.
- R11: `oe_n` and `we_n` are never low together, and `cs_n` never has more than one bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_cs | input | CS_W | Chip select addressed by the configuration write |
| cfg_wdata | input | EXT_W | Configuration write data |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | Access direction, 1 = write |
| req_cs | input | CS_W | Target chip select |
| cs_n | output | NUM_CS | Chip selects, active low |
| oe_n | output | 1 | Output enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle access completion pulse |

## Verification
A wrong count or a misdecoded wait field shows up as a strobe that is too short or too long. This is visible at `oe_n`/`we_n` on the first access that uses that field, and at the latest when the strobe should have ended. A state error shows up as a missing setup or hold cycle, which is visible within one cycle around the strobe edges, or as `done` arriving without the chip select released. Configuration captured at the wrong time only shows up when an access is compared with the one after it. The bench therefore changes the configuration in the middle of an access and measures two accesses in a row.

// File: rtl/smc_wait_pkg.sv
package smc_wait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } smc_state_e;

    localparam logic [1:0] SEL_RD_WAIT = 2'd0;
    localparam logic [1:0] SEL_WR_WAIT = 2'd1;
    localparam logic [1:0] SEL_EXT_EN  = 2'd2;
    localparam logic [1:0] SEL_LONG    = 2'd3;

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
    import smc_wait_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int NORM_W = 5,
    parameter int EXT_W  = 10,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_sel,
    input  logic [CS_W-1:0]               cfg_cs,
    input  logic [EXT_W-1:0]              cfg_wdata,
    output logic [NUM_CS-1:0][NORM_W-1:0] rd_wait,
    output logic [NUM_CS-1:0][NORM_W-1:0] wr_wait,
    output logic [NUM_CS-1:0]             ext_en,
    output logic [EXT_W-1:0]              long_wait
);

    typedef struct packed {
        logic [NUM_CS-1:0][NORM_W-1:0] rd;
        logic [NUM_CS-1:0][NORM_W-1:0] wr;
        logic [NUM_CS-1:0]             ext;
        logic [EXT_W-1:0]              lng;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_RD_WAIT: cfg_d.rd[cfg_cs]  = cfg_wdata[NORM_W-1:0];
                SEL_WR_WAIT: cfg_d.wr[cfg_cs]  = cfg_wdata[NORM_W-1:0];
                SEL_EXT_EN:  cfg_d.ext[cfg_cs] = cfg_wdata[0];
                SEL_LONG:    cfg_d.lng         = cfg_wdata;
                default:     cfg_d             = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rd_wait   = cfg_q.rd;
    assign wr_wait   = cfg_q.wr;
    assign ext_en    = cfg_q.ext;
    assign long_wait = cfg_q.lng;

endmodule

// File: rtl/smc_wait_sel.sv
module smc_wait_sel #(
    parameter int NORM_W    = 5,
    parameter int EXT_W     = 10,
    parameter int EXT_SHIFT = 4,
    localparam int CNT_W    = EXT_W + EXT_SHIFT
) (
    input  logic              write,
    input  logic              ext_mode,
    input  logic [NORM_W-1:0] rd_field,
    input  logic [NORM_W-1:0] wr_field,
    input  logic [EXT_W-1:0]  long_field,
    output logic [CNT_W-1:0]  len_m1
);

    logic [CNT_W-1:0] long_waits;
    logic [CNT_W-1:0] norm_m1;

    // normal fields encode (value + 1) wait states, so the field is already len-1
    assign norm_m1    = CNT_W'(write ? wr_field : rd_field);
    assign long_waits = {long_field, {EXT_SHIFT{1'b0}}};

    always_comb begin
        if (!ext_mode)              len_m1 = norm_m1;
        else if (long_waits == '0)  len_m1 = '0;
        else                        len_m1 = long_waits - CNT_W'(1);
    end

endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_wait_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 14,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [CNT_W-1:0]  len_m1,
    output logic [NUM_CS-1:0] cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        smc_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CS_W-1:0]  cs;
        logic             write;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.state = ST_SETUP;
                    seq_d.cs    = req_cs;
                    seq_d.write = req_write;
                    seq_d.cnt   = len_m1;
                end
            end
            ST_SETUP: seq_d.state = ST_WAIT;
            ST_WAIT: begin
                if (seq_q.cnt == '0) seq_d.state = ST_HOLD;
                else                 seq_d.cnt   = seq_q.cnt - CNT_W'(1);
            end
            ST_HOLD: begin
                seq_d.state = ST_IDLE;
                seq_d.done  = 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.state != ST_IDLE);
    assign done = seq_q.done;
    assign oe_n = !((seq_q.state == ST_WAIT) && !seq_q.write);
    assign we_n = !((seq_q.state == ST_WAIT) &&  seq_q.write);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(busy && (seq_q.cs == CS_W'(g)));
    end

endmodule

// File: rtl/smc_wait_timer.sv
module smc_wait_timer
    import smc_wait_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int NORM_W    = 5,
    parameter int EXT_W     = 10,
    parameter int EXT_SHIFT = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int CNT_W    = EXT_W + EXT_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic [EXT_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    output logic [NUM_CS-1:0] cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              busy,
    output logic              done
);

    logic [NUM_CS-1:0][NORM_W-1:0] rd_wait;
    logic [NUM_CS-1:0][NORM_W-1:0] wr_wait;
    logic [NUM_CS-1:0]             ext_en;
    logic [EXT_W-1:0]              long_wait;
    logic [CNT_W-1:0]              len_m1;

    smc_cfg_regs #(
        .NUM_CS (NUM_CS),
        .NORM_W (NORM_W),
        .EXT_W  (EXT_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_cs    (cfg_cs),
        .cfg_wdata (cfg_wdata),
        .rd_wait   (rd_wait),
        .wr_wait   (wr_wait),
        .ext_en    (ext_en),
        .long_wait (long_wait)
    );

    smc_wait_sel #(
        .NORM_W    (NORM_W),
        .EXT_W     (EXT_W),
        .EXT_SHIFT (EXT_SHIFT)
    ) i_sel (
        .write      (req_write),
        .ext_mode   (ext_en[req_cs]),
        .rd_field   (rd_wait[req_cs]),
        .wr_field   (wr_wait[req_cs]),
        .long_field (long_wait),
        .len_m1     (len_m1)
    );

    smc_seq #(
        .NUM_CS (NUM_CS),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .len_m1    (len_m1),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/smc_wait_timer_chk.sv
module smc_wait_timer_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic              done
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));                                               // R11

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));                                                 // R11

    AST_BUSY_CS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~cs_n) == 1));                               // R2

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> busy);                                       // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n && !busy));                                       // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R6

    AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                            // R6

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe_n) || $rose(we_n)) |-> (busy && oe_n && we_n));         // R6

    AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));                         // R7

endmodule

bind smc_wait_timer smc_wait_timer_chk #(.NUM_CS(NUM_CS)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .busy  (busy),
    .done  (done)
);

// File: tb/test_smc_wait_timer.sv
module test_smc_wait_timer;

    localparam int NUM_CS = 4;
    localparam int CS_W   = 2;
    localparam int EXT_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [CS_W-1:0]   cfg_cs = '0;
    logic [EXT_W-1:0]  cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [CS_W-1:0]   req_cs = '0;
    logic [NUM_CS-1:0] cs_n;
    logic              oe_n, we_n, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    smc_wait_timer #(.NUM_CS(NUM_CS)) i_smc_wait_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_cs(cfg_cs), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_write(req_write), .req_cs(req_cs), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [1:0]  cs;
        logic        wr;
        logic        ext;
        logic [4:0]  rdv;
        logic [4:0]  wrv;
        logic [9:0]  lng;
        logic [15:0] exp_len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 1'b0, 5'd0,  5'd3,  10'd0, 16'd1},
        '{2'd1, 1'b0, 1'b0, 5'd7,  5'd0,  10'd0, 16'd8},
        '{2'd2, 1'b1, 1'b0, 5'd1,  5'd31, 10'd0, 16'd32},
        '{2'd3, 1'b1, 1'b0, 5'd9,  5'd4,  10'd5, 16'd5},
        '{2'd1, 1'b0, 1'b1, 5'd2,  5'd2,  10'd3, 16'd48},
        '{2'd2, 1'b1, 1'b1, 5'd6,  5'd6,  10'd1, 16'd16},
        '{2'd0, 1'b0, 1'b1, 5'd8,  5'd8,  10'd0, 16'd1},
        '{2'd3, 1'b0, 1'b0, 5'd31, 5'd0,  10'd7, 16'd32}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [CS_W-1:0] cs,
                             input logic [EXT_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_cs = cs; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // mode 0: plain, 1: probe request while busy, 2: config write mid-access
    task automatic run_access(input logic [CS_W-1:0] cs, input logic wr,
                              input int mode, input string req, output int len);
        int other = 0;
        int cs_bad = 0;
        logic [NUM_CS-1:0] exp_cs = ~(NUM_CS'(1) << cs);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cs = cs;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy in setup", int'(busy), 1);
        chk("R2 cs_n in setup", int'(cs_n), int'(exp_cs));
        chk("R2 no strobe in setup", int'(oe_n & we_n), 1);
        len = 0;
        @(negedge clk);
        while ((wr ? !we_n : !oe_n) && len < 20000) begin
            len++;
            if (wr ? !oe_n : !we_n) other++;
            if (cs_n != exp_cs) cs_bad++;
            if (mode == 1 && len == 2) begin
                req_valid = 1'b1; req_cs = cs + 2'd1; req_write = !wr;
            end else begin
                req_valid = 1'b0; req_cs = cs; req_write = wr;
            end
            if (mode == 2 && len == 2) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_cs = cs; cfg_wdata = 10'd2;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; cfg_we = 1'b0;
        chk({req, " opposite strobe idle"}, other, 0);
        chk("R7 cs held during strobe", cs_bad, 0);
        chk("R6 hold cs", int'(cs_n), int'(exp_cs));
        chk("R6 hold strobes high", int'(oe_n & we_n), 1);
        chk("R6 hold busy", int'(busy), 1);
        @(negedge clk);
        chk("R6 done pulse", int'(done), 1);
        chk("R6 cs released", int'(cs_n), int'({NUM_CS{1'b1}}));
        chk("R6 busy low at done", int'(busy), 0);
        @(negedge clk);
        chk("R6 done one cycle", int'(done), 0);
        chk("R7 no further access", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n), int'({NUM_CS{1'b1}}));
        chk("R1 strobes in reset", int'(oe_n & we_n), 1);
        chk("R1 busy/done in reset", int'(busy | done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'({busy, done, oe_n, we_n}), 3);

        foreach (VECS[i]) begin
            cfg_write(2'd0, VECS[i].cs, 10'(VECS[i].rdv));   // R9 read wait
            cfg_write(2'd1, VECS[i].cs, 10'(VECS[i].wrv));   // R9 write wait
            cfg_write(2'd2, VECS[i].cs, 10'(VECS[i].ext));   // R9 extended bit
            cfg_write(2'd3, 2'd0, VECS[i].lng);              // R9 long wait
            run_access(VECS[i].cs, VECS[i].wr, 0, "R3 R4 R5", len);
            chk(VECS[i].ext ? "R5 extended length" :
                (VECS[i].wr ? "R4 write length" : "R3 read length"),
                len, int'(VECS[i].exp_len));
        end

        // R5: extended bit is per chip select
        cfg_write(2'd2, 2'd1, 10'd1);
        cfg_write(2'd3, 2'd0, 10'd2);
        cfg_write(2'd0, 2'd0, 10'd5);
        cfg_write(2'd2, 2'd0, 10'd0);
        run_access(2'd0, 1'b0, 0, "R5", len);
        chk("R5 normal cs unaffected", len, 6);
        run_access(2'd1, 1'b1, 0, "R5", len);
        chk("R5 extended write", len, 32);

        // R7: request while busy ignored
        cfg_write(2'd0, 2'd2, 10'd6);
        cfg_write(2'd2, 2'd2, 10'd0);
        run_access(2'd2, 1'b0, 1, "R7", len);
        chk("R7 length unchanged by probe", len, 7);

        // R8: config written mid-access applies next time
        cfg_write(2'd0, 2'd3, 10'd9);
        cfg_write(2'd2, 2'd3, 10'd0);
        run_access(2'd3, 1'b0, 2, "R8", len);
        chk("R8 current access keeps old wait", len, 10);
        run_access(2'd3, 1'b0, 0, "R8", len);
        chk("R8 next access uses new wait", len, 3);

        // R10: maximum extended wait
        cfg_write(2'd3, 2'd0, 10'd1023);
        run_access(2'd1, 1'b0, 0, "R10", len);
        chk("R10 max extended length", len, 16368);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule